// File: doc/BRIEF.md
# Condition Result Bit Packer

This block collects a stream of per-element condition-test results and folds them into integer destination elements. Each result is either a single bit or a 4-bit nibble. Each one arrives with its element index, starting at 0 and counting up through a burst. The block keeps the destination element it is currently filling. It releases that element as one write, made of a register index, a lane within that register and a zero-extended data word. The write is released when the element is full or when the burst's final result arrives.

A 2-bit packing code sets how many results share one destination element. A separate 2-bit code sets the destination element width, which may be 8, 16, 32 or 64 bits. When 4-bit results do not fit inside one element, they carry on into the next element. When an element number passes the lanes that one 64-bit register holds, it moves to the next register index. In scalar mode, every result goes into one register, at consecutive positions starting from bit 0.

Top module: `crpack`

## Requirements
- R1: After reset `wr_en` is 0, and no partially packed data is carried into the first burst.
- R2: With 1-bit results (`cfg_nib`=0), packing code 0, 1, 2 or 3 gives cnt = 1, 2, 4 or 8 results per destination element. Result i goes to element i/cnt, at LSB0 bit position i mod cnt.
- R3: In every non-scalar write, all bits of `wr_data` at and above the element width W are zero. Unpacked bits below W are also zero.
- R4: With 4-bit results (`cfg_nib`=1), cap = min(cnt, W/4). Nibble i goes to element i/cap, at bits 4*(i mod cap) through 4*(i mod cap)+3. Nibbles that do not fit carry over into the following elements.
- R5: In scalar mode (`cfg_scalar`=1), result i goes to bit i*rw of register `cfg_base`, lane 0, where rw is 1 or 4. Results with i*rw >= 64 are dropped. The register is written when its top position is filled, and again on the final result.
- R6: `cfg_wsel` 0, 1, 2 or 3 gives W = 8, 16, 32 or 64 bits. Element e is written to register `cfg_base` + e/(64/W), at lane e mod (64/W).
- R7: `wr_en` pulses one cycle after an accepted result that either fills its element or carries `in_last`. No write is made in any other cycle. After a write, the next element starts out empty.
- R8: With 1-bit results, only `in_res[0]` is used, and bits 3:1 have no effect on the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pack | input | 2 | Packing code: 1, 2, 4 or 8 results per element |
| cfg_wsel | input | 2 | Destination element width: 8, 16, 32 or 64 bits |
| cfg_nib | input | 1 | 1: 4-bit results, 0: 1-bit results |
| cfg_scalar | input | 1 | Pack every result into one register |
| cfg_base | input | REGW | First destination register index |
| in_valid | input | 1 | A result is offered this cycle |
| in_idx | input | IDXW | Element index of the result |
| in_res | input | 4 | Result value |
| in_last | input | 1 | Final result of the burst |
| wr_en | output | 1 | Write strobe |
| wr_reg | output | REGW | Destination register index |
| wr_lane | output | 3 | Element lane within the register |
| wr_data | output | 64 | Packed element, zero-extended |

## Verification
The bench aims at nibble overflow. One case is packing code 3 at an 8-bit or 16-bit width: a design that ignored the cap would write nibbles above W, or would keep one element open across eight results. Other cases are bursts that end part-way through an element, which must still produce exactly one write, and register moves when e reaches 64/W, where a wrong divisor places data on the wrong lane or register. Scalar bursts longer than the register test that out-of-range results are dropped. Junk in the upper result bits in 1-bit mode exposes a packer that uses the whole nibble.

// File: rtl/crpack.sv
module crpack #(
  parameter int IDXW = 8,
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_pack,
  input  logic [1:0]      cfg_wsel,
  input  logic            cfg_nib,
  input  logic            cfg_scalar,
  input  logic [REGW-1:0] cfg_base,
  input  logic            in_valid,
  input  logic [IDXW-1:0] in_idx,
  input  logic [3:0]      in_res,
  input  logic            in_last,
  output logic            wr_en,
  output logic [REGW-1:0] wr_reg,
  output logic [2:0]      wr_lane,
  output logic [63:0]     wr_data
);

  logic [63:0] acc;

  logic [2:0] nib_lim, capl3;
  assign nib_lim = {1'b0, cfg_wsel} + 3'd1;
  assign capl3   = (cfg_nib && ({1'b0, cfg_pack} > nib_lim)) ? nib_lim : {1'b0, cfg_pack};

  logic [1:0] capl, lprl;
  assign capl = capl3[1:0];
  assign lprl = 2'd3 - cfg_wsel;

  logic [IDXW-1:0] capmask, slot, elem;
  assign capmask = ~({IDXW{1'b1}} << capl);
  assign slot    = in_idx & capmask;
  assign elem    = in_idx >> capl;

  logic [2:0]      lane;
  logic [REGW-1:0] reg_idx;
  assign lane    = elem[2:0] & ~(3'b111 << lprl);
  assign reg_idx = cfg_base + REGW'(elem >> lprl);

  logic [5:0] pos;
  logic       in_range, full;
  always_comb begin
    if (cfg_scalar) begin
      pos      = cfg_nib ? {in_idx[3:0], 2'b00} : in_idx[5:0];
      in_range = cfg_nib ? ((in_idx >> 4) == '0) : ((in_idx >> 6) == '0);
      full     = cfg_nib ? (in_idx == IDXW'(15)) : (in_idx == IDXW'(63));
    end else begin
      pos      = cfg_nib ? {slot[3:0], 2'b00} : slot[5:0];
      in_range = 1'b1;
      full     = (slot == capmask);
    end
  end

  logic [63:0] val, merged;
  assign val    = cfg_nib ? {60'd0, in_res} : {63'd0, in_res[0]};
  assign merged = in_range ? (acc | (val << pos)) : acc;

  logic flush;
  assign flush = in_valid && (full || in_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_reg  <= '0;
      wr_lane <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= flush;
      if (in_valid) begin
        acc     <= flush ? '0 : merged;
        wr_data <= merged;
        wr_reg  <= cfg_scalar ? cfg_base : reg_idx;
        wr_lane <= cfg_scalar ? 3'd0 : lane;
      end
    end
  end

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid)) else $error("stray write"); // R7

  AST_LAST_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> wr_en) else $error("last not flushed"); // R7

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(cfg_scalar)) |-> ((wr_data >> (7'd8 << $past(cfg_wsel))) == 64'd0))
    else $error("data above element width"); // R3

  AST_SCALAR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(cfg_scalar)) |-> (wr_reg == $past(cfg_base) && wr_lane == 3'd0))
    else $error("scalar target wrong"); // R5

  AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_lane} < (4'd8 >> $past(cfg_wsel))))
    else $error("lane out of range"); // R6

endmodule

// File: tb/crpack_test.sv
module crpack_test;
  localparam int IDXW = 8;
  localparam int REGW = 5;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_pack = 0, cfg_wsel = 0;
  logic cfg_nib = 0, cfg_scalar = 0;
  logic [REGW-1:0] cfg_base = 0;
  logic in_valid = 0, in_last = 0;
  logic [IDXW-1:0] in_idx = 0;
  logic [3:0] in_res = 0;
  logic wr_en;
  logic [REGW-1:0] wr_reg;
  logic [2:0] wr_lane;
  logic [63:0] wr_data;

  int checks = 0, fails = 0;
  bit done = 0;

  crpack #(.IDXW(IDXW), .REGW(REGW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_pack(cfg_pack), .cfg_wsel(cfg_wsel),
    .cfg_nib(cfg_nib), .cfg_scalar(cfg_scalar), .cfg_base(cfg_base),
    .in_valid(in_valid), .in_idx(in_idx), .in_res(in_res), .in_last(in_last),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_lane(wr_lane), .wr_data(wr_data));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [63:0] macc;

  task automatic step(input int i, input bit last, input logic [3:0] res, input string tag);
    int cnt, rw, w, cap, lpr, e;
    bit full;
    logic [63:0] v;
    logic [REGW-1:0] ereg;
    int elane;
    cnt = 1 << cfg_pack;
    rw = cfg_nib ? 4 : 1;
    w = 8 << cfg_wsel;
    cap = cfg_nib ? ((cnt < w / 4) ? cnt : w / 4) : cnt;
    lpr = 64 / w;
    v = cfg_nib ? {60'd0, res} : {63'd0, res[0]};
    if (cfg_scalar) begin
      if (i * rw < 64) macc = macc | (v << (i * rw));
      full = (i == 64 / rw - 1);
      ereg = cfg_base;
      elane = 0;
    end else begin
      macc = macc | (v << ((i % cap) * rw));
      full = ((i % cap) == cap - 1);
      e = i / cap;
      ereg = cfg_base + REGW'(e / lpr);
      elane = e % lpr;
    end
    @(negedge clk);
    in_valid = 1; in_idx = IDXW'(i); in_res = res; in_last = last;
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk(wr_en == (full || last), "R7 strobe", 64'(wr_en), 64'(full || last));
    if (wr_en && (full || last)) begin
      chk(wr_data == macc, tag, wr_data, macc);
      chk(wr_reg == ereg && 32'(wr_lane) == elane, "R6 target", {wr_reg, wr_lane}, {ereg, 3'(elane)});
      if (!cfg_scalar && w < 64)
        chk((wr_data >> w) == 0, "R3 upper bits", wr_data >> w, 0);
      macc = 0;
    end
  endtask

  task automatic burst(input int p, input int ws, input bit nib, input bit sc, input int base,
                       input int len, input string tag, input bit junk);
    logic [3:0] r;
    cfg_pack = 2'(p); cfg_wsel = 2'(ws); cfg_nib = nib; cfg_scalar = sc; cfg_base = REGW'(base);
    macc = 0;
    for (int i = 0; i < len; i++) begin
      r = 4'($urandom);
      if (!nib && !junk) r[3:1] = 0;
      step(i, i == len - 1, r, tag);
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        chk(wr_en == 0, "R7 idle", 64'(wr_en), 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(wr_en == 0, "R1 reset strobe", 64'(wr_en), 0);
    rst_n = 1;
    @(negedge clk);
    chk(wr_en == 0, "R1 idle after reset", 64'(wr_en), 0);
    burst(3, 1, 1, 0, 2, 8, "R4 16b code3 spill", 0);
    burst(0, 1, 1, 0, 0, 3, "R4 16b code0", 0);
    burst(1, 1, 1, 0, 0, 5, "R4 16b code1 partial", 0);
    burst(2, 1, 1, 0, 4, 8, "R4 16b code2", 0);
    burst(3, 0, 1, 0, 0, 9, "R4 8b overflow", 0);
    burst(3, 2, 1, 0, 1, 8, "R4 32b eight nibbles", 0);
    burst(3, 0, 0, 0, 3, 70, "R2 8b register step", 0);
    burst(1, 3, 0, 0, 0, 5, "R2 code1", 0);
    burst(2, 2, 0, 0, 0, 13, "R8 junk upper bits", 1);
    burst(0, 0, 0, 1, 6, 40, "R5 scalar 1b", 1);
    burst(0, 0, 1, 1, 7, 20, "R5 scalar nibble overrun", 0);
    burst(0, 0, 0, 1, 0, 66, "R5 scalar overrun", 0);
    for (int k = 0; k < 250; k++)
      burst(int'($urandom % 4), int'($urandom % 4), 1'($urandom), ($urandom % 4) == 0,
            int'($urandom % 32), 1 + int'($urandom % 24), "R2 R4 random", 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule